// File: doc/BRIEF.md
# Masked SIMD Lane Writeback Unit

This block sits around the lane datapath of a packed single-precision subtract over a destination register of up to 512 bits. On an accepted request it registers the operands for each 32-bit lane and the rounding mode that the lanes must use. The minuend is always the first source and the subtrahend is always the second source. When the second source is a memory value with broadcast set, its low word feeds every lane. The floating-point arithmetic itself lives outside this block.

One cycle after the operands are presented, the block takes the per-lane difference words back from the datapath. It combines them with the old destination under a per-lane writemask, which either merges or zeroes the disabled lanes. Bits above the active vector length are cleared for the three-operand encodings and kept for the legacy two-operand encoding. The finished destination is registered and flagged with a one-cycle valid pulse.

Top module: `lane_wb_unit`

## Requirements
- R1: The vector length select `vlen_i` enables lanes 0..3 when it is 0 (128 bits), lanes 0..7 when it is 1 (256 bits), and lanes 0..15 when it is 2 or 3 (512 bits). Lane j occupies bits 32j+31:32j. The operand outputs are zero in lanes that are not enabled.
- R2: The cycle after a request with `in_valid_i` high, `op_valid_o` is high. In every enabled lane, `minuend_o` holds the first source and `subtrahend_o` holds the second source, taken in that order.
- R3: For the maskable class (`enc_i` = 2 or 3), when `src2_mem_i` = 1 and `bcast_i` = 1, every enabled lane of `subtrahend_o` holds `src2_i[31:0]`. In all other cases broadcast does not change the subtrahend.
- R4: `rmode_o` (00 nearest-even, 01 toward negative infinity, 10 toward positive infinity, 11 toward zero) equals `rc_static_i` only when the class is maskable, `src2_mem_i` = 0, `bcast_i` = 1 and the length is 512 bits. In every other case it equals `rc_ctrl_i`.
- R5: For the maskable class with `mask_en_i` = 1 and `zero_mode_i` = 0, an enabled lane whose `mask_i` bit is clear keeps its `old_dest_i` value in `dest_o`.
- R6: For the maskable class with `mask_en_i` = 1 and `zero_mode_i` = 1, an enabled lane whose `mask_i` bit is clear is 0 in `dest_o`.
- R7: An enabled lane takes its `diff_i` word when its mask bit is set or when `mask_en_i` = 0. For the legacy class (`enc_i` = 0) and the unmasked three-operand class (`enc_i` = 1), `mask_i`, `mask_en_i` and `zero_mode_i` have no effect.
- R8: For `enc_i` = 1, 2 or 3, every `dest_o` bit above the selected vector length is 0.
- R9: For the legacy class, the length is 128 bits whatever `vlen_i` is. The minuend is taken from `old_dest_i` instead of `src1_i`, and `dest_o[511:128]` keeps the `old_dest_i` value.
- R10: Mask bits at or above the enabled lane count have no effect on `dest_o`.
- R11: `diff_i` is sampled in the cycle where `op_valid_o` is high. `dest_valid_o` pulses exactly one cycle later with the combined result. Requests may arrive on consecutive cycles.
- R12: A synchronous active-high `rst` clears `op_valid_o`, `dest_valid_o` and `dest_o` at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid_i | input | 1 | Request accepted this cycle |
| src1_i | input | 512 | First source vector |
| src2_i | input | 512 | Second source, register or memory data |
| src2_mem_i | input | 1 | Second source came from memory |
| old_dest_i | input | 512 | Current destination contents |
| mask_i | input | 16 | Per-lane writemask |
| mask_en_i | input | 1 | Writemask in effect |
| zero_mode_i | input | 1 | 1 = zero disabled lanes, 0 = merge |
| bcast_i | input | 1 | Broadcast (memory) or rounding override (register) |
| vlen_i | input | 2 | Vector length select |
| enc_i | input | 2 | Encoding class: 0 legacy, 1 unmasked three-operand, 2/3 maskable |
| rc_static_i | input | 2 | Static rounding field |
| rc_ctrl_i | input | 2 | Rounding mode from the control register |
| op_valid_o | output | 1 | Operands valid, difference expected this cycle |
| minuend_o | output | 512 | Per-lane minuends |
| subtrahend_o | output | 512 | Per-lane subtrahends |
| rmode_o | output | 2 | Effective rounding mode |
| diff_i | input | 512 | Per-lane differences from the datapath |
| dest_valid_o | output | 1 | Final destination valid pulse |
| dest_o | output | 512 | Final destination |

## Verification
The operand outputs and the rounding mode are due one clock after the request edge. The combined destination is due one clock after that, so it lands two clocks after the request. The bench keeps a two-stage behavioural model that it advances once per clock. At every falling edge it compares both valids, and it compares the payload of whichever stage its model holds as valid. It drives `diff_i` from its own expected operands during the operand-valid cycle. A wrong subtrahend source or a stale sample of the difference therefore shows up in the destination as well as in the operand compare.

// File: rtl/lwb_pkg.sv
package lwb_pkg;

  typedef enum logic [1:0] {
    RM_NEAREST = 2'b00,
    RM_DOWN    = 2'b01,
    RM_UP      = 2'b10,
    RM_ZERO    = 2'b11
  } rmode_e;

  typedef enum logic [1:0] {
    ENC_LEGACY  = 2'b00,
    ENC_VEC3    = 2'b01,
    ENC_MASKED  = 2'b10,
    ENC_MASKED2 = 2'b11
  } enc_e;

  function automatic logic enc_is_masked(input logic [1:0] enc);
    return enc[1];
  endfunction

  function automatic logic enc_is_legacy(input logic [1:0] enc);
    return enc == ENC_LEGACY;
  endfunction

endpackage

// File: rtl/lwb_ctrl.sv
module lwb_ctrl
  import lwb_pkg::*;
#(
  parameter int LANES = 16
) (
  input  logic [1:0]       enc_i,
  input  logic [1:0]       vlen_i,
  input  logic [LANES-1:0] mask_i,
  input  logic             mask_en_i,
  input  logic             bcast_i,
  input  logic             src2_mem_i,
  input  logic [1:0]       rc_static_i,
  input  logic [1:0]       rc_ctrl_i,
  output logic [LANES-1:0] act_o,
  output logic [LANES-1:0] wr_o,
  output logic             bsel_o,
  output logic             legacy_o,
  output logic [1:0]       rmode_o
);
  localparam int QUARTER = LANES / 4;
  localparam int HALF    = LANES / 2;

  logic masked;
  logic full_len;

  assign masked   = enc_is_masked(enc_i);
  assign legacy_o = enc_is_legacy(enc_i);
  assign full_len = vlen_i[1];

  // Lane enables: the lowest quarter is always live, the rest follow the length.
  for (genvar i = 0; i < LANES; i++) begin : g_act
    if (i < QUARTER) begin : g_q
      assign act_o[i] = 1'b1;
    end else if (i < HALF) begin : g_h
      assign act_o[i] = !legacy_o && (vlen_i != 2'b00);
    end else begin : g_f
      assign act_o[i] = !legacy_o && full_len;
    end
  end

  always_comb begin
    if (masked && mask_en_i) wr_o = act_o & mask_i;
    else                     wr_o = act_o;
  end

  assign bsel_o = masked && src2_mem_i && bcast_i;

  always_comb begin
    if (masked && !src2_mem_i && bcast_i && full_len) rmode_o = rc_static_i;
    else                                              rmode_o = rc_ctrl_i;
  end

endmodule

// File: rtl/lwb_steer.sv
module lwb_steer #(
  parameter int LANE_W = 32,
  parameter int LANES  = 16
) (
  input  logic [LANE_W*LANES-1:0] src1_i,
  input  logic [LANE_W*LANES-1:0] src2_i,
  input  logic [LANE_W*LANES-1:0] old_dest_i,
  input  logic [LANES-1:0]        act_i,
  input  logic                    bsel_i,
  input  logic                    legacy_i,
  output logic [LANE_W*LANES-1:0] min_o,
  output logic [LANE_W*LANES-1:0] sub_o
);
  for (genvar j = 0; j < LANES; j++) begin : g_lane
    logic [LANE_W-1:0] a_src;
    logic [LANE_W-1:0] b_src;
    assign a_src = legacy_i ? old_dest_i[j*LANE_W +: LANE_W] : src1_i[j*LANE_W +: LANE_W];
    assign b_src = bsel_i   ? src2_i[LANE_W-1:0]             : src2_i[j*LANE_W +: LANE_W];
    assign min_o[j*LANE_W +: LANE_W] = act_i[j] ? a_src : '0;
    assign sub_o[j*LANE_W +: LANE_W] = act_i[j] ? b_src : '0;
  end

endmodule

// File: rtl/lwb_merge.sv
module lwb_merge #(
  parameter int LANE_W = 32,
  parameter int LANES  = 16
) (
  input  logic [LANES-1:0]        act_i,
  input  logic [LANES-1:0]        wr_i,
  input  logic                    zero_i,
  input  logic                    keep_i,
  input  logic [LANE_W*LANES-1:0] old_i,
  input  logic [LANE_W*LANES-1:0] diff_i,
  output logic [LANE_W*LANES-1:0] dest_o
);
  for (genvar j = 0; j < LANES; j++) begin : g_lane
    logic [LANE_W-1:0] old_l;
    logic [LANE_W-1:0] off_l;
    logic [LANE_W-1:0] out_l;
    assign old_l = old_i[j*LANE_W +: LANE_W];
    assign off_l = zero_i ? '0 : old_l;
    always_comb begin
      if (act_i[j])    out_l = wr_i[j] ? diff_i[j*LANE_W +: LANE_W] : off_l;
      else if (keep_i) out_l = old_l;
      else             out_l = '0;
    end
    assign dest_o[j*LANE_W +: LANE_W] = out_l;
  end

endmodule

// File: rtl/lane_wb_unit.sv
module lane_wb_unit
  import lwb_pkg::*;
#(
  parameter int LANE_W = 32,
  parameter int LANES  = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid_i,
  input  logic [LANE_W*LANES-1:0] src1_i,
  input  logic [LANE_W*LANES-1:0] src2_i,
  input  logic                    src2_mem_i,
  input  logic [LANE_W*LANES-1:0] old_dest_i,
  input  logic [LANES-1:0]        mask_i,
  input  logic                    mask_en_i,
  input  logic                    zero_mode_i,
  input  logic                    bcast_i,
  input  logic [1:0]              vlen_i,
  input  logic [1:0]              enc_i,
  input  logic [1:0]              rc_static_i,
  input  logic [1:0]              rc_ctrl_i,
  output logic                    op_valid_o,
  output logic [LANE_W*LANES-1:0] minuend_o,
  output logic [LANE_W*LANES-1:0] subtrahend_o,
  output logic [1:0]              rmode_o,
  input  logic [LANE_W*LANES-1:0] diff_i,
  output logic                    dest_valid_o,
  output logic [LANE_W*LANES-1:0] dest_o
);
  localparam int VEC_W  = LANE_W * LANES;
  localparam int BASE_W = LANE_W * (LANES / 4);

  logic [LANES-1:0] act_c, wr_c;
  logic             bsel_c, legacy_c;
  logic [1:0]       rm_c;
  logic [VEC_W-1:0] min_c, sub_c, mrg_c;

  logic [LANES-1:0] act_q, wr_q;
  logic             zero_q, keep_q;
  logic [VEC_W-1:0] old_q;

  lwb_ctrl #(.LANES(LANES)) u_ctrl (
    .enc_i       (enc_i),
    .vlen_i      (vlen_i),
    .mask_i      (mask_i),
    .mask_en_i   (mask_en_i),
    .bcast_i     (bcast_i),
    .src2_mem_i  (src2_mem_i),
    .rc_static_i (rc_static_i),
    .rc_ctrl_i   (rc_ctrl_i),
    .act_o       (act_c),
    .wr_o        (wr_c),
    .bsel_o      (bsel_c),
    .legacy_o    (legacy_c),
    .rmode_o     (rm_c)
  );

  lwb_steer #(.LANE_W(LANE_W), .LANES(LANES)) u_steer (
    .src1_i     (src1_i),
    .src2_i     (src2_i),
    .old_dest_i (old_dest_i),
    .act_i      (act_c),
    .bsel_i     (bsel_c),
    .legacy_i   (legacy_c),
    .min_o      (min_c),
    .sub_o      (sub_c)
  );

  // Stage 1: operands out to the lanes, writeback context held alongside.
  always_ff @(posedge clk) begin
    if (rst) op_valid_o <= 1'b0;
    else     op_valid_o <= in_valid_i;
  end

  always_ff @(posedge clk) begin
    if (in_valid_i) begin
      minuend_o    <= min_c;
      subtrahend_o <= sub_c;
      rmode_o      <= rm_c;
      act_q        <= act_c;
      wr_q         <= wr_c;
      zero_q       <= zero_mode_i;
      keep_q       <= legacy_c;
      old_q        <= old_dest_i;
    end
  end

  lwb_merge #(.LANE_W(LANE_W), .LANES(LANES)) u_merge (
    .act_i  (act_q),
    .wr_i   (wr_q),
    .zero_i (zero_q),
    .keep_i (keep_q),
    .old_i  (old_q),
    .diff_i (diff_i),
    .dest_o (mrg_c)
  );

  // Stage 2: combined destination.
  always_ff @(posedge clk) begin
    if (rst) begin
      dest_valid_o <= 1'b0;
      dest_o       <= '0;
    end else begin
      dest_valid_o <= op_valid_o;
      if (op_valid_o) dest_o <= mrg_c;
    end
  end

  // R11: a destination pulse follows every operand cycle and nothing else.
  a_r11_dest_follows: assert property (@(posedge clk) disable iff (rst)
    op_valid_o |=> dest_valid_o);
  a_r11_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !op_valid_o |=> !dest_valid_o);

  // R4: non-maskable classes never see the static rounding field.
  a_r4_ctrl_mode: assert property (@(posedge clk) disable iff (rst)
    (in_valid_i && !enc_i[1]) |=> (rmode_o == $past(rc_ctrl_i)));

  // R3: broadcast memory operand reaches lane 1 as the low word.
  a_r3_bcast_lane1: assert property (@(posedge clk) disable iff (rst)
    (in_valid_i && enc_i[1] && src2_mem_i && bcast_i)
      |=> (subtrahend_o[2*LANE_W-1:LANE_W] == $past(src2_i[LANE_W-1:0])));

  // R9: legacy writeback keeps the bits above the base width.
  a_r9_legacy_upper: assert property (@(posedge clk) disable iff (rst)
    (op_valid_o && keep_q) |=> (dest_o[VEC_W-1:BASE_W] == $past(old_q[VEC_W-1:BASE_W])));

  // R8: a short three-operand request leaves zeros above the base width.
  a_r8_upper_zero: assert property (@(posedge clk) disable iff (rst)
    (in_valid_i && (enc_i != 2'b00) && (vlen_i == 2'b00)) |-> ##2 (dest_o[VEC_W-1:BASE_W] == '0));

  // R12: reset clears the result and both valids.
  a_r12_reset_clear: assert property (@(posedge clk)
    rst |=> (!op_valid_o && !dest_valid_o && (dest_o == '0)));

endmodule

// File: tb/lane_wb_unit_test.sv
`timescale 1ns/1ps
module lane_wb_unit_test;
  localparam int LW = 32;
  localparam int NL = 16;
  localparam int VW = LW * NL;

  logic          clk = 1'b0;
  logic          rst;
  logic          in_valid;
  logic [VW-1:0] src1, src2, oldd, diff;
  logic          mem, men, zmode, bc;
  logic [NL-1:0] mask;
  logic [1:0]    vlen, enc, rcs, rcc;
  logic          opv, dv;
  logic [VW-1:0] mino, subo, desto;
  logic [1:0]    rmo;

  always #2.5 clk = ~clk;

  lane_wb_unit #(.LANE_W(LW), .LANES(NL)) uut (
    .clk(clk), .rst(rst), .in_valid_i(in_valid), .src1_i(src1), .src2_i(src2),
    .src2_mem_i(mem), .old_dest_i(oldd), .mask_i(mask), .mask_en_i(men),
    .zero_mode_i(zmode), .bcast_i(bc), .vlen_i(vlen), .enc_i(enc),
    .rc_static_i(rcs), .rc_ctrl_i(rcc), .op_valid_o(opv), .minuend_o(mino),
    .subtrahend_o(subo), .rmode_o(rmo), .diff_i(diff), .dest_valid_o(dv), .dest_o(desto)
  );

  int    errors = 0;
  int    checks = 0;
  bit    done   = 0;
  string cur_req = "R12";

  // Behavioural model state
  bit            m_opv, m_dv, m_zero, m_keep;
  logic [VW-1:0] m_min, m_sub, m_old, m_dest;
  logic [NL-1:0] m_act, m_wr;
  logic [1:0]    m_rm;

  task automatic chk(string what, logic [VW-1:0] act, logic [VW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", cur_req, what, act, exp);
    end
  endtask

  function automatic logic [VW-1:0] rnd_vec();
    logic [VW-1:0] v;
    for (int k = 0; k < NL; k++) v[k*LW +: LW] = $urandom;
    return v;
  endfunction

  task automatic cycle();
    logic [VW-1:0] nd;
    // compare against the model for the current cycle
    chk("op_valid", {{(VW-1){1'b0}}, opv}, {{(VW-1){1'b0}}, m_opv});
    chk("dest_valid", {{(VW-1){1'b0}}, dv}, {{(VW-1){1'b0}}, m_dv});
    if (m_opv) begin
      chk("minuend", mino, m_min);
      chk("subtrahend", subo, m_sub);
      chk("rmode", {{(VW-2){1'b0}}, rmo}, {{(VW-2){1'b0}}, m_rm});
    end
    if (m_dv || rst) chk("dest", desto, m_dest);
    // datapath answer: integer difference of the model's own operands
    if (m_opv) for (int k = 0; k < NL; k++) diff[k*LW +: LW] = m_min[k*LW +: LW] - m_sub[k*LW +: LW];
    else diff = rnd_vec();
    // advance the model by one edge
    nd = m_dest;
    if (m_opv)
      for (int k = 0; k < NL; k++) begin
        if (m_act[k]) nd[k*LW +: LW] = m_wr[k] ? diff[k*LW +: LW] : (m_zero ? '0 : m_old[k*LW +: LW]);
        else          nd[k*LW +: LW] = m_keep ? m_old[k*LW +: LW] : '0;
      end
    if (rst) begin
      m_dv = 0; m_dest = '0; m_opv = 0;
    end else begin
      m_dv = m_opv; m_dest = nd; m_opv = in_valid;
      if (in_valid) begin
        int  cnt;
        bit  lg, mk;
        lg = (enc == 2'd0);
        mk = enc[1];
        cnt = lg ? 4 : (vlen == 2'd0) ? 4 : (vlen == 2'd1) ? 8 : 16;
        for (int k = 0; k < NL; k++) begin
          m_act[k] = (k < cnt);
          m_wr[k]  = m_act[k] && (!(mk && men) || mask[k]);
          m_min[k*LW +: LW] = m_act[k] ? (lg ? oldd[k*LW +: LW] : src1[k*LW +: LW]) : '0;
          m_sub[k*LW +: LW] = m_act[k] ? ((mk && mem && bc) ? src2[LW-1:0] : src2[k*LW +: LW]) : '0;
        end
        m_rm   = (mk && !mem && bc && vlen >= 2'd2) ? rcs : rcc;
        m_zero = zmode;
        m_keep = lg;
        m_old  = oldd;
      end
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic req(bit v, logic [1:0] e, logic [1:0] l, bit m, bit b, bit me, bit z, logic [NL-1:0] mk);
    in_valid = v; enc = e; vlen = l; mem = m; bc = b; men = me; zmode = z; mask = mk;
    src1 = rnd_vec(); src2 = rnd_vec(); oldd = rnd_vec();
    rcs = 2'($urandom); rcc = 2'($urandom);
    if (rcs == rcc) rcs = ~rcc;
  endtask

  task automatic idle(int n);
    in_valid = 0;
    for (int k = 0; k < n; k++) cycle();
  endtask

  initial begin
    rst = 1; m_opv = 0; m_dv = 0; m_dest = '0;
    req(0, 2'd2, 2'd2, 0, 0, 0, 0, '0);
    diff = '0;
    @(negedge clk);
    cur_req = "R12 reset";
    cycle(); cycle();
    rst = 0;
    chk("reset dest", desto, '0);
    idle(1);

    cur_req = "R1 R2 R7 full unmasked";
    req(1, 2'd2, 2'd2, 0, 0, 0, 0, 16'h0000); cycle(); idle(2);
    cur_req = "R1 R2 length 256";
    req(1, 2'd3, 2'd1, 0, 0, 0, 0, '0); cycle(); idle(2);
    cur_req = "R5 merge masking";
    req(1, 2'd2, 2'd2, 0, 0, 1, 0, 16'hA5C3); cycle(); idle(2);
    cur_req = "R6 zero masking";
    req(1, 2'd2, 2'd2, 1, 0, 1, 1, 16'h3C0F); cycle(); idle(2);
    cur_req = "R3 R8 broadcast 256";
    req(1, 2'd2, 2'd1, 1, 1, 1, 1, 16'h00F3); cycle(); idle(2);
    cur_req = "R4 static rounding 512";
    req(1, 2'd2, 2'd2, 0, 1, 0, 0, '0); cycle(); idle(2);
    cur_req = "R4 override ignored at 256";
    req(1, 2'd2, 2'd1, 0, 1, 0, 0, '0); cycle(); idle(2);
    cur_req = "R4 R3 memory broadcast keeps ctrl mode";
    req(1, 2'd3, 2'd3, 1, 1, 0, 0, '0); cycle(); idle(2);
    cur_req = "R7 R8 unmasked class ignores mask";
    req(1, 2'd1, 2'd0, 1, 1, 1, 1, 16'h0000); cycle(); idle(2);
    cur_req = "R9 legacy keeps upper";
    req(1, 2'd0, 2'd2, 0, 1, 1, 1, 16'h0000); cycle(); idle(2);
    cur_req = "R10 upper mask bits ignored";
    req(1, 2'd2, 2'd0, 0, 0, 1, 0, 16'hFFF5); cycle(); idle(2);

    cur_req = "R11 back to back";
    for (int t = 0; t < 40; t++) begin
      req(1, 2'($urandom), 2'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
          1'($urandom), 16'($urandom));
      cycle();
    end
    idle(3);

    cur_req = "R12 reset mid stream";
    req(1, 2'd2, 2'd2, 0, 0, 0, 0, '0); cycle();
    req(1, 2'd1, 2'd1, 0, 0, 0, 0, '0); rst = 1; cycle();
    rst = 0; in_valid = 0; cycle();
    chk("dest after reset", desto, '0);
    idle(2);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL R11 watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule